// File: doc/BRIEF.md
# Holdover and Reference Switchover Controller

This block sits between a phase-lock loop and a digitally controlled oscillator. While a reference is healthy, it passes the loop's live frequency word straight to the oscillator and reports which of two references, A or B, is being tracked. When tracking can no longer continue, it enters holdover. It then freezes the oscillator at a static tuning word captured on the entry cycle. That word is either the averaged word or the last valid loop word, as a control bit selects.

Holdover ends in one of two ways. In manual mode the controller follows an external hold pin. In automatic mode it ignores the pin and watches both references. It resumes on the first one that becomes usable, and A wins a tie. An optional revert control moves tracking back from B to A once A is usable again. On every exit from holdover, a one-cycle strobe and a preload word let the loop filter seed its integrator with the frequency that was held.

Top module: `hold_switch_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the controller is in holdover (`in_hold`=1), `ref_sel`=0 (0 selects reference A, 1 selects B), `tune_word`=0, `preload_word`=0 and `resume_pulse`=0.
- R2: Outside holdover, `tune_word` equals `loop_word` in the same cycle.
- R3: On the clock edge that enters holdover, the held word is captured from `avg_word` if `use_avg`=1 and from `last_word` otherwise. From then until holdover exits, `tune_word` and `preload_word` stay at that value whatever the word inputs do.
- R4: In manual mode (`auto_mode`=0), `hold_pin`=1 while tracking enters holdover on the next edge. This takes precedence over every other transition.
- R5: In manual mode, `hold_pin`=0 during holdover leaves holdover on the next edge. Tracking resumes on the reference that `ref_sel` last named.
- R6: In automatic mode, holdover exits on the next edge once a reference is usable, meaning `ref_ok`=1 and `ref_fault`=0 for that bit (bit 0 is A). If A and B are both usable, A is chosen.
- R7: If the tracked reference is not usable and no earlier rule applies, the controller moves to the other reference if that one is usable. Otherwise it enters holdover.
- R8: While tracking B with `revert_en`=1 and A usable, the controller moves to A on the next edge. With `revert_en`=0 it stays on B while B is usable.
- R9: `resume_pulse` is high for exactly the first cycle after holdover exits. During that cycle `preload_word` still holds the held word.
- R10: In automatic mode, `hold_pin` has no effect on state or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ok | input | 2 | Validated-reference flags, bit 0 = A, bit 1 = B |
| ref_fault | input | 2 | Fault flags, same bit order |
| hold_pin | input | 1 | Manual holdover request |
| auto_mode | input | 1 | 1 = automatic exit, 0 = manual pin control |
| revert_en | input | 1 | Allow return from B to A |
| use_avg | input | 1 | Held word source: 1 = averaged, 0 = last valid |
| loop_word | input | WORD_W | Live loop frequency word |
| avg_word | input | WORD_W | Averaged frequency word |
| last_word | input | WORD_W | Last valid loop word |
| tune_word | output | WORD_W | Word driven to the oscillator |
| in_hold | output | 1 | Holdover status |
| ref_sel | output | 1 | Tracked (or last tracked) reference |
| resume_pulse | output | 1 | One-cycle strobe after holdover exit |
| preload_word | output | WORD_W | Held word for integrator preload |

## Verification
The hardest case to reach is a tie in automatic mode. From holdover, both references must turn usable on the same edge, and the controller must pick A. A second hard case is a held word that has to stay fixed while its source inputs keep changing. The stimulus sets up both cases directly. It drives both faults high to force holdover, then clears both faults in one cycle, and it randomises the word inputs on every cycle of holdover. A long random run with sparse faults, occasional mode flips and a cycle-accurate bench model then covers the interleavings of pin, revert and fault events.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    localparam int NUM_REF = 2;

    typedef enum logic [1:0] {
        ST_TRACK_A = 2'd0,
        ST_TRACK_B = 2'd1,
        ST_HOLD    = 2'd2
    } hsw_state_e;

    typedef struct packed {
        logic auto_mode;
        logic revert_en;
        logic use_avg;
        logic hold_pin;
    } hsw_ctrl_t;

    function automatic logic ref_usable(input logic ok, input logic fault);
        return ok & ~fault;
    endfunction

    function automatic hsw_state_e track_of(input logic sel);
        return sel ? ST_TRACK_B : ST_TRACK_A;
    endfunction

endpackage

// File: rtl/hsw_ref_qual.sv
module hsw_ref_qual
    import hsw_pkg::*;
(
    input  logic [NUM_REF-1:0] ref_ok,
    input  logic [NUM_REF-1:0] ref_fault,
    output logic [NUM_REF-1:0] usable
);
    for (genvar i = 0; i < NUM_REF; i++) begin : g_ref
        assign usable[i] = ref_usable(ref_ok[i], ref_fault[i]);
    end
endmodule

// File: rtl/hsw_next_state.sv
module hsw_next_state
    import hsw_pkg::*;
(
    input  hsw_state_e         cur,
    input  logic               sel,
    input  hsw_ctrl_t          ctrl,
    input  logic [NUM_REF-1:0] usable,
    output hsw_state_e         nxt
);
    logic active_ok;
    logic other_ok;

    always_comb begin
        active_ok = usable[sel];
        other_ok  = usable[~sel];
        nxt       = cur;
        if (cur == ST_HOLD) begin
            if (ctrl.auto_mode) begin
                if (usable[0])      nxt = ST_TRACK_A;
                else if (usable[1]) nxt = ST_TRACK_B;
            end else if (!ctrl.hold_pin) begin
                nxt = track_of(sel);
            end
        end else begin
            if (!ctrl.auto_mode && ctrl.hold_pin) begin
                nxt = ST_HOLD;
            end else if (sel && ctrl.revert_en && usable[0]) begin
                nxt = ST_TRACK_A;
            end else if (!active_ok) begin
                nxt = other_ok ? track_of(~sel) : ST_HOLD;
            end
        end
    end
endmodule

// File: rtl/hsw_hold_reg.sv
module hsw_hold_reg #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              use_avg,
    input  logic [WORD_W-1:0] avg_word,
    input  logic [WORD_W-1:0] last_word,
    output logic [WORD_W-1:0] held
);
    logic [WORD_W-1:0] src;

    assign src = use_avg ? avg_word : last_word;

    always_ff @(posedge clk) begin
        if (rst)          held <= '0;
        else if (capture) held <= src;
    end
endmodule

// File: rtl/hold_switch_ctrl.sv
module hold_switch_ctrl
    import hsw_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        ref_ok,
    input  logic [1:0]        ref_fault,
    input  logic              hold_pin,
    input  logic              auto_mode,
    input  logic              revert_en,
    input  logic              use_avg,
    input  logic [WORD_W-1:0] loop_word,
    input  logic [WORD_W-1:0] avg_word,
    input  logic [WORD_W-1:0] last_word,
    output logic [WORD_W-1:0] tune_word,
    output logic              in_hold,
    output logic              ref_sel,
    output logic              resume_pulse,
    output logic [WORD_W-1:0] preload_word
);
    hsw_state_e         state_q, state_d;
    logic               sel_q;
    logic               pulse_q;
    logic [NUM_REF-1:0] usable;
    logic [WORD_W-1:0]  held;
    hsw_ctrl_t          ctrl;
    logic               entering;
    logic               leaving;

    assign ctrl = '{auto_mode: auto_mode, revert_en: revert_en,
                    use_avg: use_avg, hold_pin: hold_pin};

    hsw_ref_qual u_qual (
        .ref_ok   (ref_ok),
        .ref_fault(ref_fault),
        .usable   (usable)
    );

    hsw_next_state u_fsm (
        .cur   (state_q),
        .sel   (sel_q),
        .ctrl  (ctrl),
        .usable(usable),
        .nxt   (state_d)
    );

    assign entering = (state_q != ST_HOLD) && (state_d == ST_HOLD);
    assign leaving  = (state_q == ST_HOLD) && (state_d != ST_HOLD);

    hsw_hold_reg #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .capture  (entering),
        .use_avg  (use_avg),
        .avg_word (avg_word),
        .last_word(last_word),
        .held     (held)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HOLD;
            sel_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= leaving;
            if (state_d != ST_HOLD) sel_q <= (state_d == ST_TRACK_B);
        end
    end

    assign in_hold      = (state_q == ST_HOLD);
    assign ref_sel      = sel_q;
    assign resume_pulse = pulse_q;
    assign tune_word    = in_hold ? held : loop_word;
    assign preload_word = held;
endmodule

// File: rtl/hsw_checker.sv
module hsw_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        ref_ok,
    input logic [1:0]        ref_fault,
    input logic              hold_pin,
    input logic              auto_mode,
    input logic              revert_en,
    input logic [WORD_W-1:0] tune_word,
    input logic              in_hold,
    input logic              ref_sel,
    input logic              resume_pulse,
    input logic [WORD_W-1:0] preload_word
);
    logic ua, ub;
    assign ua = ref_ok[0] & ~ref_fault[0];
    assign ub = ref_ok[1] & ~ref_fault[1];

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (in_hold && $past(in_hold)) |-> (tune_word == $past(tune_word)));

    a_r9_pulse_on_exit: assert property (@(posedge clk) disable iff (rst)
        $fell(in_hold) |-> resume_pulse);

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |=> !resume_pulse);

    a_r9_pulse_after_hold: assert property (@(posedge clk) disable iff (rst)
        resume_pulse |-> (!in_hold && preload_word == $past(preload_word)));

    a_r4_pin_enters: assert property (@(posedge clk) disable iff (rst)
        (!auto_mode && hold_pin && !in_hold) |=> in_hold);

    a_r6_auto_prefers_a: assert property (@(posedge clk) disable iff (rst)
        (auto_mode && in_hold && ua) |=> (!in_hold && !ref_sel));

    a_r7_no_ref_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_hold && !ua && !ub) |=> in_hold);

    a_r8_revert_to_a: assert property (@(posedge clk) disable iff (rst)
        (!in_hold && ref_sel && revert_en && ua && (auto_mode || !hold_pin))
        |=> (!in_hold && !ref_sel));
endmodule

bind hold_switch_ctrl hsw_checker #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_ok      (ref_ok),
    .ref_fault   (ref_fault),
    .hold_pin    (hold_pin),
    .auto_mode   (auto_mode),
    .revert_en   (revert_en),
    .tune_word   (tune_word),
    .in_hold     (in_hold),
    .ref_sel     (ref_sel),
    .resume_pulse(resume_pulse),
    .preload_word(preload_word)
);

// File: tb/hold_switch_ctrl_test.sv
module hold_switch_ctrl_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   ref_ok, ref_fault;
    logic         hold_pin, auto_mode, revert_en, use_avg;
    logic [W-1:0] loop_word, avg_word, last_word;
    logic [W-1:0] tune_word, preload_word;
    logic         in_hold, ref_sel, resume_pulse;

    always #5 clk = ~clk;

    hold_switch_ctrl #(.WORD_W(W)) uut (
        .clk(clk), .rst(rst), .ref_ok(ref_ok), .ref_fault(ref_fault),
        .hold_pin(hold_pin), .auto_mode(auto_mode), .revert_en(revert_en),
        .use_avg(use_avg), .loop_word(loop_word), .avg_word(avg_word),
        .last_word(last_word), .tune_word(tune_word), .in_hold(in_hold),
        .ref_sel(ref_sel), .resume_pulse(resume_pulse), .preload_word(preload_word)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state: 0 = track A, 1 = track B, 2 = holdover
    int           m_st;
    bit           m_sel, m_res;
    logic [W-1:0] m_held;

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int model_next(input int st, input bit sel);
        bit ua = ref_ok[0] && !ref_fault[0];
        bit ub = ref_ok[1] && !ref_fault[1];
        bit act, oth;
        if (st == 2) begin
            if (auto_mode) return ua ? 0 : (ub ? 1 : 2);
            return hold_pin ? 2 : int'(sel);
        end
        act = sel ? ub : ua;
        oth = sel ? ua : ub;
        if (!auto_mode && hold_pin) return 2;
        if (sel && revert_en && ua) return 0;
        if (!act) return oth ? int'(!sel) : 2;
        return st;
    endfunction

    task automatic step();
        int nx;
        logic [W-1:0] exp_tune;
        #1;
        exp_tune = (m_st == 2) ? m_held : loop_word;
        chk(in_hold == (m_st == 2), "R7 in_hold", W'(in_hold), W'(m_st == 2));
        chk(ref_sel == m_sel, "R7 ref_sel", W'(ref_sel), W'(m_sel));
        chk(tune_word == exp_tune, (m_st == 2) ? "R3 held tune_word" : "R2 live tune_word",
            tune_word, exp_tune);
        chk(resume_pulse == m_res, "R9 resume_pulse", W'(resume_pulse), W'(m_res));
        chk(preload_word == m_held, "R9 preload_word", preload_word, m_held);
        nx = model_next(m_st, m_sel);
        @(posedge clk);
        if (m_st != 2 && nx == 2) m_held = use_avg ? avg_word : last_word;
        m_res = (m_st == 2 && nx != 2);
        if (nx != 2) m_sel = (nx == 1);
        m_st = nx;
        @(negedge clk);
    endtask

    task automatic drive(input logic [1:0] ok, input logic [1:0] f, input bit pin,
                         input bit au, input bit rv, input bit src);
        ref_ok = ok; ref_fault = f; hold_pin = pin;
        auto_mode = au; revert_en = rv; use_avg = src;
        loop_word = $urandom; avg_word = $urandom; last_word = $urandom;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        drive(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(in_hold && !ref_sel && !resume_pulse, "R1 reset flags",
            {in_hold, ref_sel, resume_pulse}, 3'b100);
        chk(tune_word == 0 && preload_word == 0, "R1 reset words", tune_word, 0);
        rst = 1'b0;
        m_st = 2; m_sel = 0; m_res = 0; m_held = '0;

        // R5 manual exit on pin release, to last selected ref (A)
        drive(2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1); step();
        chk(!in_hold && !ref_sel, "R5 manual exit to A", {in_hold, ref_sel}, 2'b00);
        chk(resume_pulse, "R9 strobe after exit", W'(resume_pulse), 1);
        // R4 pin enters holdover, captured from avg
        drive(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1); step();
        chk(in_hold && tune_word == m_held, "R4 pin enters hold", W'(in_hold), 1);
        for (int i = 0; i < 4; i++) begin
            drive(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0); step();
        end
        // R6 + R10 auto exits to A despite pin
        drive(2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0); step();
        chk(!in_hold && !ref_sel, "R6 auto exit picks A", {in_hold, ref_sel}, 2'b00);
        drive(2'b11, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0); step();
        chk(!in_hold, "R10 pin ignored in auto", W'(in_hold), 0);
        // R7 fault on A moves to B
        drive(2'b11, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0); step();
        chk(!in_hold && ref_sel, "R7 switch to B", {in_hold, ref_sel}, 2'b01);
        // R8 no revert when disabled
        drive(2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0); step(); step();
        chk(ref_sel, "R8 stays on B without revert", W'(ref_sel), 1);
        drive(2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0); step();
        chk(!ref_sel && !in_hold, "R8 revert to A", W'(ref_sel), 0);
        // R7 both faulty -> hold, last_word source
        drive(2'b11, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0); step();
        chk(in_hold, "R7 no usable ref enters hold", W'(in_hold), 1);
        // R6 tie: both usable same cycle -> A
        drive(2'b11, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0); step();
        chk(!in_hold && !ref_sel, "R6 tie favours A", {in_hold, ref_sel}, 2'b00);
        // R6 only B usable
        drive(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0); step();
        drive(2'b10, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0); step();
        chk(!in_hold && ref_sel, "R6 auto exit to B", {in_hold, ref_sel}, 2'b01);
        // R5 manual exit returns to B
        drive(2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1); step();
        drive(2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1); step();
        chk(!in_hold && ref_sel, "R5 manual exit to B", {in_hold, ref_sel}, 2'b01);

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] ok, f;
            ok = {($urandom % 8) != 0, ($urandom % 8) != 0};
            f  = {($urandom % 6) == 0, ($urandom % 6) == 0};
            drive(ok, f, ($urandom % 4) == 0,
                  (n / 200) % 2 == 1, ($urandom % 3) == 0, $urandom % 2);
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule